// File: doc/BRIEF.md
# Period-Match Timer with Prescale and Postscale

This block is an up-counter that advances on an instruction-cycle tick after a selectable coarse divider. It starts from zero and compares its count with a programmable period value on every clock. On a divided tick where the two are equal, the counter returns to zero. One clock later the block produces a one-cycle match pulse, which another block can use as a serial shift clock. A second, programmable divider counts these match events. When that divider reaches its selected count, it sets a sticky interrupt flag.

Software reaches the block through a small synchronous register port with four locations: count, period, control and status. The control byte holds the run enable, the coarse divider code and the match-divider code. A write to the count or to the control byte empties both dividers. A control write leaves the count unchanged.

Top module: `period_timer`

## Requirements
- R1: After reset, the count reads 00h, the period reads FFh, the control byte reads 00h, the status reads 00h, and `match_o` and `irq_o` are low.
- R2: Register addresses are 0 = count, 1 = period, 2 = control, 3 = status. In the control byte, bits 1:0 are the prescale code, bit 2 is the run enable and bits 6:3 are the postscale code. Bit 7 of the control byte always reads 0. Status bit 0 is the interrupt flag.
- R3: Prescale code 00 gives one count step per tick, code 01 gives one step every 4 ticks, and codes 10 and 11 both give one step every 16 ticks.
- R4: The count rises by one on each divided tick. It holds its value while the run enable is 0 or while `tick_i` is low.
- R5: On a divided tick with count equal to period, the count returns to 00h and `match_o` is high for exactly the following cycle. Starting from a count w ≤ P, the first match comes after (P−w+1) divided ticks. Later matches come every (P+1) divided ticks. A period of 00h gives a match on every divided tick.
- R6: With postscale code N, the interrupt flag is set on the (N+1)-th match after the match divider was last emptied. The match divider then restarts from zero.
- R7: The interrupt flag stays set until a write to status with bit 0 = 1. A status write with bit 0 = 0 has no effect.
- R8: A write to the count or to the control byte empties the prescaler and the match divider. A control write leaves the count unchanged.
- R9: A count write takes priority over the increment and over the match reset in the same cycle. The written value is read back in the next cycle.
- R10: Reads are combinational and have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Instruction-cycle tick enable |
| bus_addr_i | input | 2 | Register select |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for the selected register |
| match_o | output | 1 | One-cycle pulse after a period match |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
A wrong prescaler phase or terminal value moves every match pulse by whole multiples of the divide ratio. The scoreboard sees this on the first expected match after enabling, because it compares arrival cycles exactly. A match divider that is off by one raises `irq_o` one match early or late, and this shows at the match where the flag is sampled. A missed flush on a count or control write shows within a single period as a stray early match or interrupt. An increment that beats a count write shows in the very next read.

// File: rtl/timer_pkg.sv
package timer_pkg;
   typedef enum logic [1:0] {
      A_COUNT  = 2'd0,
      A_PERIOD = 2'd1,
      A_CTRL   = 2'd2,
      A_STAT   = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic       rsv;
      logic [3:0] post_sel;
      logic       run;
      logic [1:0] pre_sel;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PRE_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       run,
   input  logic       tick,
   input  logic [1:0] sel,
   output logic       step
);
   logic [PRE_W-1:0] cnt;
   logic [PRE_W-1:0] term;
   logic             advance;

   if (PRE_W < 4) begin : g_bad_pre
      $error("tmr_prescaler: PRE_W must be at least 4");
   end

   always_comb begin
      unique casez (sel)
         2'b00:   term = '0;
         2'b01:   term = PRE_W'(3);
         default: term = PRE_W'(15);
      endcase
   end

   assign advance = run & tick & ~clr;
   assign step    = advance & (cnt == term);

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (clr)     cnt <= '0;
      else if (advance) cnt <= (cnt == term) ? '0 : cnt + 1'b1;
   end

   p_presc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= term);
   p_presc_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic [W-1:0] period,
   output logic [W-1:0] count,
   output logic         hit
);
   logic at_end;

   assign at_end = (count == period);
   assign hit    = step & at_end & ~load;

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (load) count <= load_val;
      else if (step) count <= at_end ? '0 : count + 1'b1;
   end

   p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count == $past(load_val));
   p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load && count != period |=> count == $past(count) + W'(1));
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !step && !load |=> $stable(count));
   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> count == '0);
endmodule

// File: rtl/tmr_postscaler.sv
module tmr_postscaler #(
   parameter int PS_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            evt,
   input  logic [PS_W-1:0] ratio,
   input  logic            flag_clr,
   output logic            flag
);
   logic [PS_W-1:0] cnt;
   logic            last;
   logic            set;

   assign last = (cnt == ratio);
   assign set  = evt & last & ~clr;

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (evt) cnt <= last ? '0 : cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        flag <= 1'b0;
      else if (set)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
   end

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= ratio);
   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !flag_clr |=> flag);
   p_flag_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr && !evt |=> !flag);
endmodule

// File: rtl/period_timer.sv
module period_timer
   import timer_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int PRE_W = 4,
   parameter int PS_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [1:0]       bus_addr_i,
   input  logic             bus_wr_i,
   input  logic [CNT_W-1:0] bus_wdata_i,
   output logic [CNT_W-1:0] bus_rdata_o,
   output logic             match_o,
   output logic             irq_o
);
   localparam int PAD_W = CNT_W - CTRL_W;

   if (CNT_W < CTRL_W) begin : g_bad_w
      $error("period_timer: CNT_W must hold the control byte");
   end
   if (PS_W < 1 || PS_W > 4) begin : g_bad_ps
      $error("period_timer: PS_W must be 1..4");
   end

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] period_q;
   logic [CNT_W-1:0] count;
   logic             cnt_wr, ctl_wr, per_wr, stat_clr;
   logic             flush, step, hit;
   logic [CNT_W-1:0] ctrl_rd;
   logic [CNT_W-1:0] stat_rd;

   assign cnt_wr   = bus_wr_i && (bus_addr_i == A_COUNT);
   assign per_wr   = bus_wr_i && (bus_addr_i == A_PERIOD);
   assign ctl_wr   = bus_wr_i && (bus_addr_i == A_CTRL);
   assign stat_clr = bus_wr_i && (bus_addr_i == A_STAT) && bus_wdata_i[0];
   assign flush    = cnt_wr | ctl_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         period_q <= '1;
      end else begin
         if (ctl_wr) begin
            ctrl_q     <= ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
            ctrl_q.rsv <= 1'b0;
         end
         if (per_wr) period_q <= bus_wdata_i;
      end
   end

   tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (flush),
      .run  (ctrl_q.run),
      .tick (tick_i),
      .sel  (ctrl_q.pre_sel),
      .step (step)
   );

   tmr_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cnt_wr),
      .load_val(bus_wdata_i),
      .step    (step),
      .period  (period_q),
      .count   (count),
      .hit     (hit)
   );

   tmr_postscaler #(.PS_W(PS_W)) u_post (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (flush),
      .evt     (hit),
      .ratio   (ctrl_q.post_sel[PS_W-1:0]),
      .flag_clr(stat_clr),
      .flag    (irq_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) match_o <= 1'b0;
      else        match_o <= hit;
   end

   if (PAD_W > 0) begin : g_pad
      assign ctrl_rd = {{PAD_W{1'b0}}, 1'b0, ctrl_q[CTRL_W-2:0]};
   end else begin : g_nopad
      assign ctrl_rd = {1'b0, ctrl_q[CTRL_W-2:0]};
   end
   assign stat_rd = {{(CNT_W-1){1'b0}}, irq_o};

   always_comb begin
      unique case (bus_addr_i)
         A_COUNT:  bus_rdata_o = count;
         A_PERIOD: bus_rdata_o = period_q;
         A_CTRL:   bus_rdata_o = ctrl_rd;
         default:  bus_rdata_o = stat_rd;
      endcase
   end

   p_match_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      match_o && period_q != '0 |=> !match_o);
   p_ctrl_keeps_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && !cnt_wr |=> count == $past(count) || count == '0 || count == $past(count) + CNT_W'(1));
endmodule

// File: tb/test_period_timer.sv
module test_period_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       match_o, irq_o;

   int n_chk = 0;
   int n_err = 0;
   int ecnt = 0;
   int exp_q[$];
   bit mon_on = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) ecnt <= ecnt + 1;

   period_timer i_period_timer (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata),
      .bus_rdata_o(bus_rdata), .match_o(match_o), .irq_o(irq_o)
   );

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // scoreboard monitor: each match pulse must land on the next expected edge
   always @(negedge clk) begin
      if (mon_on && match_o) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_err++;
            $display("FAIL R5: actual=match at edge %0d expected=no match", ecnt);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (e != ecnt) begin
               n_err++;
               $display("FAIL R5: actual=edge %0d expected=edge %0d", ecnt, e);
            end
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [7:0] ctl(input logic en, input logic [1:0] pre, input logic [3:0] post);
      return {1'b0, post, en, pre};
   endfunction

   task automatic wait_edge(input int target);
      while (ecnt < target) @(negedge clk);
   endtask

   // driver: configure, enable, push expected match edges, then check the flag
   task automatic run_cfg(input string req, input logic [1:0] pre, input int div,
                          input int p, input int w, input int n, input int k);
      int n0, last;
      wr(2'd2, ctl(1'b0, pre, 4'(n)));
      wr(2'd1, 8'(p));
      wr(2'd0, 8'(w));
      wr(2'd3, 8'h01);
      wr(2'd2, ctl(1'b1, pre, 4'(n)));
      n0 = ecnt;
      for (int j = 0; j < k; j++) exp_q.push_back(n0 + (p - w + 1) * div + j * (p + 1) * div);
      last = exp_q[k-1];
      mon_on = 1'b1;
      wait_edge(last);
      #1 mon_on = 1'b0;
      chk({req, " pending matches"}, exp_q.size(), 0);
      exp_q.delete();
      chk("R6 flag after matches", int'(irq_o), (k >= n + 1) ? 1 : 0);
      wr(2'd2, ctl(1'b0, pre, 4'(n)));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      logic [7:0] d, d2;
      int n1;
      repeat (3) @(negedge clk);
      chk("R1 match low in reset", int'(match_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(2'd0, d); chk("R1 count", d, 8'h00);
      rd(2'd1, d); chk("R1 period", d, 8'hFF);
      rd(2'd2, d); chk("R1 control", d, 8'h00);
      rd(2'd3, d); chk("R1 status", d, 8'h00);
      chk("R1 irq", int'(irq_o), 0);
      @(negedge clk);
      // R2 bit 7 of control reads 0, other bits land
      wr(2'd2, 8'hFB);
      rd(2'd2, d); chk("R2 control bit7", d, 8'h7B);
      wr(2'd2, 8'h00);
      // R10 reads have no side effects
      rd(2'd1, d); rd(2'd1, d2); chk("R10 repeat read", d2, d);

      // R3/R5 divide-by-1, R6 postscale 1:4
      run_cfg("R5 div1", 2'b00, 1, 5, 0, 3, 4);
      run_cfg("R6 flag not early", 2'b00, 1, 5, 0, 2, 2);
      run_cfg("R6 flag at third", 2'b00, 1, 5, 0, 2, 3);
      // R3 divide-by-4
      run_cfg("R3 div4", 2'b01, 4, 3, 1, 15, 3);
      // R3 both 1x codes divide by 16
      run_cfg("R3 code10", 2'b10, 16, 2, 2, 15, 2);
      run_cfg("R3 code11", 2'b11, 16, 2, 2, 15, 2);
      // R5 period zero matches every tick
      run_cfg("R5 period0", 2'b00, 1, 0, 0, 0, 5);

      // R7 status write of 0 has no effect, write of 1 clears
      chk("R7 flag set before", int'(irq_o), 1);
      wr(2'd3, 8'h00);
      chk("R7 zero write keeps", int'(irq_o), 1);
      wr(2'd3, 8'h01);
      chk("R7 w1c clears", int'(irq_o), 0);

      // R4 hold while disabled; R8 control write keeps count
      wr(2'd0, 8'd7);
      repeat (20) @(negedge clk);
      rd(2'd0, d); chk("R4 hold disabled", d, 7);
      wr(2'd2, ctl(1'b0, 2'b11, 4'd9));
      rd(2'd0, d); chk("R8 ctrl write keeps count", d, 7);
      // R4 hold while tick low
      tick = 1'b0;
      wr(2'd2, ctl(1'b1, 2'b00, 4'd0));
      repeat (10) @(negedge clk);
      rd(2'd0, d); chk("R4 hold tick low", d, 7);
      tick = 1'b1;
      #1 @(negedge clk);
      rd(2'd0, d); chk("R4 step resumes", d, 8);

      // R9 count write beats increment; written value equal to period
      wr(2'd1, 8'd10);
      @(negedge clk);
      wr(2'd0, 8'd3);
      rd(2'd0, d); chk("R9 load beats step", d, 3);
      @(negedge clk);
      rd(2'd0, d); chk("R4 next step", d, 4);
      wr(2'd0, 8'd10);
      rd(2'd0, d); chk("R9 load beats match reset", d, 10);
      chk("R9 no match on load", int'(match_o), 0);
      @(negedge clk);
      rd(2'd0, d); chk("R5 wrap to zero", d, 0);
      chk("R5 match pulse", int'(match_o), 1);
      @(negedge clk);
      chk("R5 pulse one cycle", int'(match_o), 0);

      // R8 count write flushes match divider (postscale 1:2)
      wr(2'd2, ctl(1'b0, 2'b00, 4'd1));
      wr(2'd1, 8'd3);
      wr(2'd0, 8'd0);
      wr(2'd3, 8'h01);
      wr(2'd2, ctl(1'b1, 2'b00, 4'd1));
      n1 = ecnt;
      wait_edge(n1 + 4);
      #1 chk("R5 first match", int'(match_o), 1);
      chk("R6 one match no flag", int'(irq_o), 0);
      wr(2'd0, 8'd0);
      n1 = ecnt;
      wait_edge(n1 + 4);
      #1 chk("R8 flushed divider", int'(irq_o), 0);
      wait_edge(n1 + 8);
      #1 chk("R6 flag on second", int'(irq_o), 1);
      wr(2'd2, 8'h00);

      summary();
   end
endmodule